// File: doc/BRIEF.md
# Flash Write-Status Read Generator

This block is a cycle-level model of the read behaviour of a NOR-style flash array while an internal write is in progress. Writes arrive through a single-cycle synchronous write port and are decoded by an unlock sequencer. A complete program or erase sequence starts an internal operation. The operation lasts a fixed number of clock cycles, which is set by a parameter per operation class. While it runs, every read returns a status word instead of array data. When the operation ends, the array content is updated in the same clock edge that clears the busy state. After that edge, reads return the new data.

The status word carries two indicators. Bit 7 is a complemented-data bit that depends on the operation class. Bit 6 is a toggle bit that alternates from one read to the next. A host uses either of them to detect that the write has finished. Writes made while an operation is running are discarded. They neither start an operation nor move the sequencer forward.

The array is held in the block as a small parameterised word store. Sectors and blocks are aligned power-of-two groups of words.

Top module: `flash_wstat_gen`

## Requirements
- R1: After reset, `busy` is low and every array word reads FFFFh.
- R2: A write series of AAh at key address 5555h, then 55h at 2AAAh, then A0h at 5555h, then a fourth write carrying (target, word) starts a program. Only data bits 7:0 are decoded in key writes, and only address bits 14:0 are compared. `busy` is high from the edge of the fourth write for exactly T_PROG cycles. Afterwards the target reads back the word.
- R3: After the five writes AAh@5555h, 55h@2AAAh, 80h@5555h, AAh@5555h, 55h@2AAAh, the sixth write selects the erase. Code 30h erases the 2^SECT_LW-word sector that holds the written address. Code 50h erases the 2^BLK_LW-word block that holds it. Code 10h at 5555h erases the whole array. `busy` lasts T_ERASE cycles (sector or block) or T_CHIP cycles (whole array). Erased words read FFFFh and all other words are unchanged.
- R4: During a program, bit 7 of every read is the inverse of bit 7 of the word being programmed.
- R5: During any erase, bit 7 of every read is 0.
- R6: While busy, bit 6 flips on every read and holds between reads. The first read of each operation returns 1, because the toggle restarts at 0 when the operation is launched.
- R7: While busy, read bits 15:8 and 5:0 are 0.
- R8: A write issued while `busy` is high is ignored. It neither launches an operation nor advances or resets the unlock sequence.
- R9: A write that does not match the expected step of a sequence returns the sequencer to idle. This includes an erase code that is not one of the three defined codes, and a whole-array erase code written at an address other than 5555h. Such a write launches nothing.
- R10: `rd_data` is registered one cycle after `rd_en` and holds while `rd_en` is low. A read issued in a cycle where `busy` is high returns the whole status word. A read issued where `busy` is low returns the whole array word, including the effect of an operation that has just completed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe, one write per cycle |
| wr_addr | input | AW | Write address |
| wr_data | input | 16 | Write data; low byte decoded in key writes |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | AW | Read address |
| rd_data | output | 16 | Registered read word: status while busy, array data otherwise |
| busy | output | 1 | Internal operation in progress |

## Verification
Every array word is programmed, using program words whose bit 7 takes both values. The read spacing during each busy window is varied: back to back, and with one or two idle cycles between reads. This separates a toggle that follows reads from one that follows the clock. Sector, block and whole-array erases are each followed by a full array sweep, which shows whether the erase touched exactly its aligned region. Unlock series that are complete, that arrive while an operation is busy, that are split across the end of an operation, or that carry a wrong step are all applied. Together they tell apart a sequencer that freezes, one that resets, and one that keeps running during an operation.

// File: rtl/flash_ws_pkg.sv
package flash_ws_pkg;

  typedef enum logic [1:0] {
    OP_PROG = 2'd0,
    OP_SECT = 2'd1,
    OP_BLK  = 2'd2,
    OP_CHIP = 2'd3
  } op_e;

  typedef enum logic [2:0] {
    SQ_IDLE = 3'd0,
    SQ_U1   = 3'd1,
    SQ_U2   = 3'd2,
    SQ_PRG  = 3'd3,
    SQ_E1   = 3'd4,
    SQ_E2   = 3'd5,
    SQ_E3   = 3'd6
  } seq_e;

  localparam logic [14:0] KEY_HI = 15'h5555;
  localparam logic [14:0] KEY_LO = 15'h2AAA;

  localparam logic [7:0] CD_UNL1  = 8'hAA;
  localparam logic [7:0] CD_UNL2  = 8'h55;
  localparam logic [7:0] CD_PROG  = 8'hA0;
  localparam logic [7:0] CD_ERASE = 8'h80;
  localparam logic [7:0] CD_SECT  = 8'h30;
  localparam logic [7:0] CD_BLK   = 8'h50;
  localparam logic [7:0] CD_CHIP  = 8'h10;

  // duration in cycles of one internal operation
  function automatic int op_cycles(input op_e op, input int tp, input int te, input int tc);
    case (op)
      OP_PROG: op_cycles = tp;
      OP_CHIP: op_cycles = tc;
      default: op_cycles = te;
    endcase
  endfunction

  // does word index idx fall inside the region an operation on tgt touches
  function automatic logic region_hit(input int unsigned idx, input int unsigned tgt,
                                      input op_e op, input int sect_lw, input int blk_lw);
    case (op)
      OP_PROG: region_hit = (idx == tgt);
      OP_SECT: region_hit = ((idx >> sect_lw) == (tgt >> sect_lw));
      OP_BLK:  region_hit = ((idx >> blk_lw) == (tgt >> blk_lw));
      default: region_hit = 1'b1;
    endcase
  endfunction

  // status word returned by a read while an operation is running
  function automatic logic [15:0] status_word(input op_e op, input logic prog_b7, input logic tgl);
    status_word    = 16'h0000;
    status_word[7] = (op == OP_PROG) ? ~prog_b7 : 1'b0;
    status_word[6] = tgl;
  endfunction

endpackage

// File: rtl/flash_ws_cmdseq.sv
module flash_ws_cmdseq
  import flash_ws_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          busy_i,
  input  logic          wr_en_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [15:0]   wr_data_i,
  output logic          launch_o,
  output op_e           op_o,
  output logic [AW-1:0] tgt_o,
  output logic [15:0]   word_o
);

  seq_e       st_q, st_d;
  logic       take;
  logic       at_hi, at_lo;
  logic [7:0] code;
  logic       erase_code_ok;
  logic       unused_addr_hi;

  assign take           = wr_en_i && !busy_i;
  assign at_hi          = (wr_addr_i[14:0] == KEY_HI);
  assign at_lo          = (wr_addr_i[14:0] == KEY_LO);
  assign code           = wr_data_i[7:0];
  assign unused_addr_hi = ^wr_addr_i[AW-1:15];

  assign erase_code_ok = (code == CD_SECT) || (code == CD_BLK) ||
                         ((code == CD_CHIP) && at_hi);

  always_comb begin
    st_d = st_q;
    if (take) begin
      case (st_q)
        SQ_IDLE: st_d = (at_hi && code == CD_UNL1) ? SQ_U1 : SQ_IDLE;
        SQ_U1:   st_d = (at_lo && code == CD_UNL2) ? SQ_U2 : SQ_IDLE;
        SQ_U2: begin
          if (at_hi && code == CD_PROG)       st_d = SQ_PRG;
          else if (at_hi && code == CD_ERASE) st_d = SQ_E1;
          else                                st_d = SQ_IDLE;
        end
        SQ_E1:   st_d = (at_hi && code == CD_UNL1) ? SQ_E2 : SQ_IDLE;
        SQ_E2:   st_d = (at_lo && code == CD_UNL2) ? SQ_E3 : SQ_IDLE;
        default: st_d = SQ_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st_q <= SQ_IDLE;
    else        st_q <= st_d;
  end

  assign launch_o = take && ((st_q == SQ_PRG) || ((st_q == SQ_E3) && erase_code_ok));

  always_comb begin
    if (st_q == SQ_PRG)        op_o = OP_PROG;
    else if (code == CD_SECT)  op_o = OP_SECT;
    else if (code == CD_BLK)   op_o = OP_BLK;
    else                       op_o = OP_CHIP;
  end

  assign tgt_o  = wr_addr_i;
  assign word_o = wr_data_i;

  AST_SEQ_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    busy_i |=> $stable(st_q)); // R8
  AST_SEQ_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
    (take && st_q == SQ_U1 && !(at_lo && code == CD_UNL2)) |=> (st_q == SQ_IDLE)); // R9

endmodule

// File: rtl/flash_ws_timer.sv
module flash_ws_timer
  import flash_ws_pkg::*;
#(
  parameter int T_PROG  = 8,
  parameter int T_ERASE = 20,
  parameter int T_CHIP  = 40
) (
  input  logic clk,
  input  logic rst_n,
  input  logic launch_i,
  input  op_e  op_i,
  output logic busy_o,
  output logic done_o,
  output op_e  op_q_o
);

  localparam int TMAX = (T_PROG > T_ERASE) ? ((T_PROG > T_CHIP) ? T_PROG : T_CHIP)
                                           : ((T_ERASE > T_CHIP) ? T_ERASE : T_CHIP);
  localparam int CW   = $clog2(TMAX + 1);

  logic [CW-1:0] cnt_q;
  logic          busy_q;
  op_e           op_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      op_q   <= OP_PROG;
    end else if (launch_i) begin
      busy_q <= 1'b1;
      cnt_q  <= CW'(op_cycles(op_i, T_PROG, T_ERASE, T_CHIP) - 1);
      op_q   <= op_i;
    end else if (busy_q) begin
      if (cnt_q == '0) busy_q <= 1'b0;
      else             cnt_q  <= cnt_q - 1'b1;
    end
  end

  assign busy_o = busy_q;
  assign done_o = busy_q && (cnt_q == '0);
  assign op_q_o = op_q;

  AST_LAUNCH_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    launch_i |-> !busy_q); // R8
  AST_BUSY_START: assert property (@(posedge clk) disable iff (!rst_n)
    launch_i |=> busy_q); // R2

endmodule

// File: rtl/flash_ws_array.sv
module flash_ws_array
  import flash_ws_pkg::*;
#(
  parameter int ARR_W   = 6,
  parameter int SECT_LW = 2,
  parameter int BLK_LW  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             launch_i,
  input  logic [ARR_W-1:0] tgt_i,
  input  logic [15:0]      word_i,
  input  op_e              op_i,
  input  logic             done_i,
  input  logic [ARR_W-1:0] rd_addr_i,
  output logic [15:0]      rd_word_o,
  output logic             prog_b7_o
);

  localparam int DEPTH = 1 << ARR_W;

  logic [15:0]      mem_q [DEPTH];
  logic [ARR_W-1:0] tgt_q;
  logic [15:0]      word_q;
  logic [DEPTH-1:0] hit;

  for (genvar g = 0; g < DEPTH; g++) begin : g_hit
    assign hit[g] = region_hit(g, 32'(tgt_q), op_i, SECT_LW, BLK_LW);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tgt_q  <= '0;
      word_q <= 16'h0000;
    end else if (launch_i) begin
      tgt_q  <= tgt_i;
      word_q <= word_i;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= 16'hFFFF;
    end else if (done_i) begin
      for (int i = 0; i < DEPTH; i++) begin
        if (hit[i]) mem_q[i] <= (op_i == OP_PROG) ? word_q : 16'hFFFF;
      end
    end
  end

  assign rd_word_o = mem_q[rd_addr_i];
  assign prog_b7_o = word_q[7];

  AST_PROG_LAND: assert property (@(posedge clk) disable iff (!rst_n)
    (done_i && op_i == OP_PROG) |=> (mem_q[tgt_q] == word_q)); // R2
  AST_ERASE_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    (done_i && op_i != OP_PROG) |=> (mem_q[tgt_q] == 16'hFFFF)); // R3

endmodule

// File: rtl/flash_ws_rdport.sv
module flash_ws_rdport
  import flash_ws_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        launch_i,
  input  logic        busy_i,
  input  op_e         op_i,
  input  logic        prog_b7_i,
  input  logic        rd_en_i,
  input  logic [15:0] arr_word_i,
  output logic [15:0] rd_data_o
);

  logic        tgl_q;
  logic [15:0] rd_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tgl_q <= 1'b0;
      rd_q  <= 16'h0000;
    end else begin
      if (launch_i)                tgl_q <= 1'b0;
      else if (rd_en_i && busy_i)  tgl_q <= ~tgl_q;
      if (rd_en_i)
        rd_q <= busy_i ? status_word(op_i, prog_b7_i, ~tgl_q) : arr_word_i;
    end
  end

  assign rd_data_o = rd_q;

  AST_STATUS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en_i && busy_i) |=> (rd_data_o[15:8] == 8'h00 && rd_data_o[5:0] == 6'h00)); // R7
  AST_ERASE_DQ7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en_i && busy_i && op_i != OP_PROG) |=> !rd_data_o[7]); // R5
  AST_PROG_DQ7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en_i && busy_i && op_i == OP_PROG) |=> (rd_data_o[7] == !$past(prog_b7_i))); // R4
  AST_TGL_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    launch_i |=> !tgl_q); // R6
  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en_i |=> $stable(rd_data_o)); // R10

endmodule

// File: rtl/flash_wstat_gen.sv
module flash_wstat_gen
  import flash_ws_pkg::*;
#(
  parameter int AW      = 16,
  parameter int ARR_W   = 6,
  parameter int SECT_LW = 2,
  parameter int BLK_LW  = 4,
  parameter int T_PROG  = 8,
  parameter int T_ERASE = 20,
  parameter int T_CHIP  = 40
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [15:0]   wr_data,
  input  logic          rd_en,
  input  logic [AW-1:0] rd_addr,
  output logic [15:0]   rd_data,
  output logic          busy
);

  logic          launch;
  op_e           op_new;
  op_e           op_run;
  logic [AW-1:0] tgt_new;
  logic [15:0]   word_new;
  logic          busy_w;
  logic          done_w;
  logic          prog_b7;
  logic [15:0]   arr_word;
  logic          unused_bits;

  assign unused_bits = ^{rd_addr[AW-1:ARR_W], tgt_new[AW-1:ARR_W]};

  flash_ws_cmdseq #(.AW(AW)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy_i    (busy_w),
    .wr_en_i   (wr_en),
    .wr_addr_i (wr_addr),
    .wr_data_i (wr_data),
    .launch_o  (launch),
    .op_o      (op_new),
    .tgt_o     (tgt_new),
    .word_o    (word_new)
  );

  flash_ws_timer #(.T_PROG(T_PROG), .T_ERASE(T_ERASE), .T_CHIP(T_CHIP)) u_tmr (
    .clk      (clk),
    .rst_n    (rst_n),
    .launch_i (launch),
    .op_i     (op_new),
    .busy_o   (busy_w),
    .done_o   (done_w),
    .op_q_o   (op_run)
  );

  flash_ws_array #(.ARR_W(ARR_W), .SECT_LW(SECT_LW), .BLK_LW(BLK_LW)) u_arr (
    .clk       (clk),
    .rst_n     (rst_n),
    .launch_i  (launch),
    .tgt_i     (tgt_new[ARR_W-1:0]),
    .word_i    (word_new),
    .op_i      (op_run),
    .done_i    (done_w),
    .rd_addr_i (rd_addr[ARR_W-1:0]),
    .rd_word_o (arr_word),
    .prog_b7_o (prog_b7)
  );

  flash_ws_rdport u_rd (
    .clk        (clk),
    .rst_n      (rst_n),
    .launch_i   (launch),
    .busy_i     (busy_w),
    .op_i       (op_run),
    .prog_b7_i  (prog_b7),
    .rd_en_i    (rd_en),
    .arr_word_i (arr_word),
    .rd_data_o  (rd_data)
  );

  assign busy = busy_w;

endmodule

// File: tb/flash_wstat_gen_tb.sv
`timescale 1ns/1ps
module flash_wstat_gen_tb;

  localparam int AW      = 16;
  localparam int ARR_W   = 6;
  localparam int SECT_LW = 2;
  localparam int BLK_LW  = 4;
  localparam int T_PROG  = 8;
  localparam int T_ERASE = 20;
  localparam int T_CHIP  = 40;
  localparam int DEPTH   = 1 << ARR_W;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [15:0] wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [15:0] rd_addr = '0;
  logic [15:0] rd_data;
  logic        busy;

  int          n_chk = 0;
  int          n_err = 0;
  logic [15:0] model [DEPTH];

  always #2.5 clk = ~clk;

  flash_wstat_gen #(.AW(AW), .ARR_W(ARR_W), .SECT_LW(SECT_LW), .BLK_LW(BLK_LW),
                    .T_PROG(T_PROG), .T_ERASE(T_ERASE), .T_CHIP(T_CHIP)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .busy(busy)
  );

  task automatic chk(input logic ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // one bus cycle; inputs are driven at a falling edge, bb is busy before the rising edge
  task automatic step(input logic we, input logic [15:0] wa, input logic [15:0] wd,
                      input logic re, input logic [15:0] ra, output logic bb);
    wr_en = we; wr_addr = wa; wr_data = wd; rd_en = re; rd_addr = ra;
    bb = busy;
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
  endtask

  task automatic wr(input logic [15:0] a, input logic [15:0] d);
    logic bb;
    step(1'b1, a, d, 1'b0, 16'h0, bb);
  endtask

  task automatic prog_seq(input logic [15:0] a, input logic [15:0] w, input logic hi_bits);
    wr(hi_bits ? 16'hD555 : 16'h5555, 16'hFFAA);
    wr(hi_bits ? 16'hAAAA : 16'h2AAA, 16'h3355);
    wr(hi_bits ? 16'hD555 : 16'h5555, 16'h00A0);
    wr(a, w);
  endtask

  task automatic erase_seq(input logic [15:0] a, input logic [7:0] cd);
    wr(16'h5555, 16'h00AA);
    wr(16'h2AAA, 16'h0055);
    wr(16'h5555, 16'h0080);
    wr(16'h5555, 16'h00AA);
    wr(16'h2AAA, 16'h0055);
    wr(a, {8'h00, cd});
  endtask

  // read address a until busy falls; check every status word and the busy length
  task automatic poll(input logic [15:0] a, input logic is_prog, input logic [15:0] w,
                      input int expect_len, input int already, input int gap, input string tag);
    int          seen;
    logic        t;
    logic        bb;
    logic        fin;
    logic [15:0] e;
    seen = already; t = 1'b0; fin = 1'b0;
    while (!fin) begin
      step(1'b0, 16'h0, 16'h0, 1'b1, a, bb);
      if (bb) begin
        seen++;
        t = ~t;
        e = 16'h0000;
        e[7] = is_prog ? ~w[7] : 1'b0;
        e[6] = t;
        chk(rd_data == e, {tag, " status word (R4 R5 R6 R7)"}, rd_data, e);
        for (int k = 0; k < gap; k++) begin
          step(1'b0, 16'h0, 16'h0, 1'b0, 16'h0, bb);
          if (bb) seen++;
        end
      end else begin
        fin = 1'b1;
        chk(rd_data == model[a[ARR_W-1:0]], {tag, " data after completion R10"},
            rd_data, model[a[ARR_W-1:0]]);
      end
      if (seen > expect_len + 8) fin = 1'b1;
    end
    chk(seen == expect_len, {tag, " busy length R2 R3"}, 16'(seen), 16'(expect_len));
  endtask

  task automatic verify_all(input string tag);
    logic bb;
    for (int i = 0; i < DEPTH; i++) begin
      step(1'b0, 16'h0, 16'h0, 1'b1, 16'(i), bb);
      chk(rd_data == model[i], tag, rd_data, model[i]);
    end
  endtask

  task automatic idle_no_busy(input string tag);
    logic bb;
    for (int k = 0; k < 3; k++) begin
      step(1'b0, 16'h0, 16'h0, 1'b0, 16'h0, bb);
      chk(!busy, tag, {15'h0, busy}, 16'h0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    logic        bb;
    logic [15:0] w;
    logic [15:0] a;
    for (int i = 0; i < DEPTH; i++) model[i] = 16'hFFFF;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    chk(!busy, "R1 busy low after reset", {15'h0, busy}, 16'h0);
    verify_all("R1 erased after reset");

    // R2 R4 R6 R7: program every word, varying read spacing and key high bits
    for (int i = 0; i < DEPTH; i++) begin
      w = 16'(i * 2909 + 16'h1357);
      a = 16'(i) | ((i % 2) == 1 ? 16'hC000 : 16'h0000);
      model[i] = w;
      prog_seq(a, w, (i % 2) == 1);
      chk(busy, "R2 busy after fourth write", {15'h0, busy}, 16'h1);
      poll(a, 1'b1, w, T_PROG, 0, i % 3, "R2 program");
    end
    verify_all("R2 readback");

    // R10: output holds without a read strobe
    step(1'b0, 16'h0, 16'h0, 1'b1, 16'd3, bb);
    step(1'b0, 16'h0, 16'h0, 1'b0, 16'd9, bb);
    step(1'b0, 16'h0, 16'h0, 1'b0, 16'd9, bb);
    chk(rd_data == model[3], "R10 hold without read", rd_data, model[3]);

    // R8: a full program series during busy is discarded
    model[5] = 16'h0F7E;
    prog_seq(16'd5, 16'h0F7E, 1'b0);
    prog_seq(16'd6, 16'h1234, 1'b0);
    poll(16'd5, 1'b1, 16'h0F7E, T_PROG, 4, 0, "R8 program under writes");
    idle_no_busy("R8 no launch from busy writes");
    step(1'b0, 16'h0, 16'h0, 1'b1, 16'd6, bb);
    chk(rd_data == model[6], "R8 target untouched", rd_data, model[6]);

    // R8: a series split across the end of an operation does not complete
    model[8] = 16'h8001;
    prog_seq(16'd8, 16'h8001, 1'b0);
    wr(16'h5555, 16'h00AA);
    wr(16'h2AAA, 16'h0055);
    wr(16'h0000, 16'h00F0);
    poll(16'd8, 1'b1, 16'h8001, T_PROG, 3, 0, "R8 split series");
    wr(16'h5555, 16'h00A0);
    wr(16'd9, 16'h0F0F);
    idle_no_busy("R8 split series no launch");
    step(1'b0, 16'h0, 16'h0, 1'b1, 16'd9, bb);
    chk(rd_data == model[9], "R8 split series target", rd_data, model[9]);

    // R9: wrong third step aborts
    wr(16'h5555, 16'h00AA);
    wr(16'h2AAA, 16'h0055);
    wr(16'h5555, 16'h0077);
    wr(16'h5555, 16'h00A0);
    wr(16'd10, 16'h0000);
    idle_no_busy("R9 abort on wrong code");
    step(1'b0, 16'h0, 16'h0, 1'b1, 16'd10, bb);
    chk(rd_data == model[10], "R9 word unchanged", rd_data, model[10]);

    // R9: undefined sixth code and whole-array code off the key address
    erase_seq(16'd12, 8'h20);
    idle_no_busy("R9 undefined erase code");
    erase_seq(16'd1, 8'h10);
    idle_no_busy("R9 whole-array code at wrong address");
    verify_all("R9 array unchanged");

    // sequencer is back to idle: a valid program works
    model[10] = 16'h0080;
    prog_seq(16'd10, 16'h0080, 1'b0);
    poll(16'd10, 1'b1, 16'h0080, T_PROG, 0, 1, "R9 recovery program");

    // R3 R5: sector erase around word 0x25
    for (int i = 0; i < DEPTH; i++) if ((i >> SECT_LW) == (16'h25 >> SECT_LW)) model[i] = 16'hFFFF;
    erase_seq(16'h0025, 8'h30);
    poll(16'h0025, 1'b0, 16'h0, T_ERASE, 0, 1, "R3 sector erase");
    verify_all("R3 sector region");

    // R3 R5: block erase around word 0x13
    for (int i = 0; i < DEPTH; i++) if ((i >> BLK_LW) == (16'h13 >> BLK_LW)) model[i] = 16'hFFFF;
    erase_seq(16'h0013, 8'h50);
    poll(16'h0013, 1'b0, 16'h0, T_ERASE, 0, 2, "R3 block erase");
    verify_all("R3 block region");

    // R3 R5 R6: whole-array erase
    for (int i = 0; i < DEPTH; i++) model[i] = 16'hFFFF;
    erase_seq(16'h5555, 8'h10);
    poll(16'h0030, 1'b0, 16'h0, T_CHIP, 0, 0, "R3 whole-array erase");
    verify_all("R3 whole array");

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule